// File: doc/BRIEF.md
# Parallel Programming Strobe Sequencer

This block sits on the host side of a parallel programming link. It generates the strobes that a target device expects: a latch clock that captures data and control, a page-load strobe, an active-low write strobe and an active-low output enable. It also drives the two byte-select lines and the outgoing data bus, and it watches the target's ready/busy line. Every minimum setup, hold and pulse width is a parameter in cycles of the local clock. The defaults assume a 100 MHz clock, so each count is the nanosecond figure divided by 10 and rounded up.

A client issues one operation at a time through a request port: latch a byte, pulse the page-load strobe, write, chip erase, or read a byte. The block accepts a request only while it is idle. It plays the strobe sequence with the requested byte and byte-select value. When the sequence ends it raises a one-cycle completion pulse. That pulse carries a timeout qualifier for writes and erases whose busy handshake did not finish in time. Command encodings, address ordering and the high programming voltage are the client's concern.

Top module: `pp_strobe_seq`

## Requirements
- R1: While idle, `reqReady` is 1, `tgtWrN` and `tgtOeN` are 1, and `tgtXclk` and `tgtPagel` are 0. A request is taken only when `reqValid` is high in an idle cycle and `reqOp` is one of the codes latch=0, page-load=1, write=2, read=3, erase=4. Any other code, and any request made while busy, has no effect on the outputs or on the completion count.
- R2: Latch: the byte-select lines (`tgtBs1` = `reqBs[0]`, `tgtBs2` = `reqBs[1]`) and `tgtDataOut` are stable for at least SETUP_CYC cycles before `tgtXclk` rises. `tgtXclk` stays high for at least XHIGH_CYC cycles. After it falls, at least max(HOLD_CYC, XPERIOD_CYC-XHIGH_CYC) cycles pass before the next request can change the bus.
- R3: Page-load: `tgtBs1` is stable for at least SETUP_CYC cycles before `tgtPagel` rises. The strobe stays high for at least PHIGH_CYC cycles. After it falls, at least max(BSHOLD_CYC, PL2XH_CYC, PL2WL_CYC) cycles pass before the next request can act.
- R4: Write and erase: the byte-select lines are stable for at least SETUP_CYC cycles before `tgtWrN` falls, and `tgtWrN` stays low for at least WLOW_CYC cycles.
- R5: If ready/busy goes low within BUSYLOW_MAX cycles of the write fall and returns high within the operation's limit, completion comes without timeout. It comes at least BSHOLD_CYC cycles after ready/busy rises, with the byte-select lines unchanged. A busy pulse that begins and ends while `tgtWrN` is still low counts as a valid handshake.
- R6: If ready/busy has not gone low within BUSYLOW_MAX cycles of the write fall, the operation completes with `timedOut` set.
- R7: If ready/busy stays low beyond WRITE_MAX cycles for a write, or beyond ERASE_MAX cycles for an erase, the operation completes with `timedOut` set. An erase busy time that lies above the write limit but within the erase limit completes without timeout.
- R8: Read: `tgtOeN` goes low and the data bus is not driven. `rdData` takes the value present on `tgtDataIn` once `tgtOeN` has been low for RDVALID_CYC cycles, not earlier.
- R9: After a read, `tgtOeN` is high for at least FLOAT_CYC cycles before completion.
- R10: `doneValid` is a single-cycle pulse, and `timedOut` is only ever 1 together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 3 | Operation code |
| reqData | input | DATA_W | Byte to present for a latch |
| reqBs | input | 2 | Byte-select value, bit 0 to select line 1 |
| reqReady | output | 1 | Idle, request can be taken |
| doneValid | output | 1 | One-cycle completion pulse |
| timedOut | output | 1 | Completion was a busy-handshake timeout |
| rdData | output | DATA_W | Byte captured by the last read |
| tgtXclk | output | 1 | Latch clock to target |
| tgtPagel | output | 1 | Page-load strobe |
| tgtWrN | output | 1 | Write strobe, active low |
| tgtOeN | output | 1 | Output enable, active low |
| tgtBs1 | output | 1 | Byte-select line 1 |
| tgtBs2 | output | 1 | Byte-select line 2 |
| tgtDataOut | output | DATA_W | Outgoing data bus value |
| tgtDataOe | output | 1 | Host drives the data bus |
| tgtDataIn | input | DATA_W | Incoming data bus value |
| tgtRdy | input | 1 | Target ready (1) / busy (0) |

## Verification
The busy pulse can begin and end while the write strobe is still low. In that case the busy detection and the write-pulse timing act in the same cycles. The bench provokes this with a target model that pulls ready/busy low for three cycles right after it sees the write fall. The case is judged correct when the operation completes without timeout and the write pulse keeps its full width. A second overlap happens when a request arrives in the middle of an erase. The bench checks that the bus, the select lines, the latch-clock edge count and the completion count are all untouched.

// File: rtl/ppseq_pkg.sv
package ppseq_pkg;

  typedef enum logic [2:0] {
    OP_LATCH = 3'd0,
    OP_PAGE  = 3'd1,
    OP_WRITE = 3'd2,
    OP_READ  = 3'd3,
    OP_ERASE = 3'd4
  } ppOpE;

  // Strobe bundle from control to datapath
  typedef struct packed {
    logic xclk;
    logic pagel;
    logic wrN;
    logic oeN;
    logic driveData;
    logic load;
    logic sample;
  } ppStrobeT;

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ppseq_ctrl.sv
module ppseq_ctrl
  import ppseq_pkg::*;
#(
  parameter int SETUP_CYC   = 7,
  parameter int XHIGH_CYC   = 15,
  parameter int XPERIOD_CYC = 30,
  parameter int HOLD_CYC    = 7,
  parameter int PHIGH_CYC   = 20,
  parameter int PL2XH_CYC   = 15,
  parameter int PL2WL_CYC   = 7,
  parameter int WLOW_CYC    = 15,
  parameter int BSHOLD_CYC  = 7,
  parameter int BUSYLOW_MAX = 100,
  parameter int WRITE_MAX   = 450000,
  parameter int ERASE_MAX   = 1200000,
  parameter int RDVALID_CYC = 50,
  parameter int FLOAT_CYC   = 50
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic [2:0] reqOp,
  input  logic     rdyBsy,
  output ppStrobeT stb,
  output logic     reqReady,
  output logic     doneValid,
  output logic     timedOut
);

  localparam int XHOLD_CYC = maxi(HOLD_CYC, XPERIOD_CYC - XHIGH_CYC);
  localparam int PTAIL_CYC = maxi(BSHOLD_CYC, maxi(PL2XH_CYC, PL2WL_CYC));
  localparam int PH_MAX = maxi(maxi(maxi(SETUP_CYC, XHIGH_CYC), maxi(XHOLD_CYC, PHIGH_CYC)),
                               maxi(maxi(PTAIL_CYC, WLOW_CYC), maxi(maxi(BSHOLD_CYC, RDVALID_CYC + 1), FLOAT_CYC)));
  localparam int PH_W  = $clog2(PH_MAX + 1);
  localparam int TMR_W = $clog2(maxi(maxi(ERASE_MAX, WRITE_MAX), BUSYLOW_MAX) + 1);

  localparam logic [PH_W-1:0] SETUP_L  = PH_W'(SETUP_CYC - 1);
  localparam logic [PH_W-1:0] XHIGH_L  = PH_W'(XHIGH_CYC - 1);
  localparam logic [PH_W-1:0] XHOLD_L  = PH_W'(XHOLD_CYC - 1);
  localparam logic [PH_W-1:0] PHIGH_L  = PH_W'(PHIGH_CYC - 1);
  localparam logic [PH_W-1:0] PTAIL_L  = PH_W'(PTAIL_CYC - 1);
  localparam logic [PH_W-1:0] WLOW_L   = PH_W'(WLOW_CYC - 1);
  localparam logic [PH_W-1:0] BSHOLD_L = PH_W'(BSHOLD_CYC - 1);
  localparam logic [PH_W-1:0] RDV_L    = PH_W'(RDVALID_CYC);
  localparam logic [PH_W-1:0] FLOAT_L  = PH_W'(FLOAT_CYC - 1);
  localparam logic [TMR_W-1:0] BUSYLOW_L = TMR_W'(BUSYLOW_MAX - 1);
  localparam logic [TMR_W-1:0] WMAX_L    = TMR_W'(WRITE_MAX - 1);
  localparam logic [TMR_W-1:0] EMAX_L    = TMR_W'(ERASE_MAX - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_XHIGH, S_XHOLD, S_PHIGH, S_PTAIL,
    S_WLOW, S_WWAIT, S_WHOLD, S_RWAIT, S_RFLOAT
  } seqStateE;

  seqStateE         state;
  ppOpE             opQ;
  logic [PH_W-1:0]  phCnt;
  logic [TMR_W-1:0] busyT;
  logic             sawBusy;
  logic             doneQ;
  logic             toQ;
  logic             opValid;
  logic [TMR_W-1:0] busyLimit;

  assign opValid   = (reqOp <= 3'd4);
  assign busyLimit = (opQ == OP_ERASE) ? EMAX_L : WMAX_L;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opQ     <= OP_LATCH;
      phCnt   <= '0;
      busyT   <= '0;
      sawBusy <= 1'b0;
      doneQ   <= 1'b0;
      toQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      toQ   <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (reqValid && opValid) begin
            opQ   <= ppOpE'(reqOp);
            phCnt <= '0;
            state <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (phCnt == SETUP_L) begin
            phCnt <= '0;
            unique case (opQ)
              OP_LATCH: state <= S_XHIGH;
              OP_PAGE:  state <= S_PHIGH;
              OP_READ:  state <= S_RWAIT;
              default: begin
                state   <= S_WLOW;
                busyT   <= '0;
                sawBusy <= 1'b0;
              end
            endcase
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        S_XHIGH: begin
          if (phCnt == XHIGH_L) begin
            phCnt <= '0;
            state <= S_XHOLD;
          end else phCnt <= phCnt + 1'b1;
        end
        S_XHOLD: begin
          if (phCnt == XHOLD_L) begin
            state <= S_IDLE;
            doneQ <= 1'b1;
          end else phCnt <= phCnt + 1'b1;
        end
        S_PHIGH: begin
          if (phCnt == PHIGH_L) begin
            phCnt <= '0;
            state <= S_PTAIL;
          end else phCnt <= phCnt + 1'b1;
        end
        S_PTAIL: begin
          if (phCnt == PTAIL_L) begin
            state <= S_IDLE;
            doneQ <= 1'b1;
          end else phCnt <= phCnt + 1'b1;
        end
        S_WLOW: begin
          busyT <= busyT + 1'b1;
          if (!rdyBsy) sawBusy <= 1'b1;
          if (phCnt == WLOW_L) begin
            phCnt <= '0;
            state <= S_WWAIT;
          end else phCnt <= phCnt + 1'b1;
        end
        S_WWAIT: begin
          busyT <= busyT + 1'b1;
          if (!rdyBsy) sawBusy <= 1'b1;
          // ready returning wins over a limit reached in the same cycle
          if (sawBusy && rdyBsy) begin
            phCnt <= '0;
            state <= S_WHOLD;
          end else if ((!sawBusy && rdyBsy && busyT >= BUSYLOW_L) || (busyT >= busyLimit)) begin
            state <= S_IDLE;
            doneQ <= 1'b1;
            toQ   <= 1'b1;
          end
        end
        S_WHOLD: begin
          if (phCnt == BSHOLD_L) begin
            state <= S_IDLE;
            doneQ <= 1'b1;
          end else phCnt <= phCnt + 1'b1;
        end
        S_RWAIT: begin
          if (phCnt == RDV_L) begin
            phCnt <= '0;
            state <= S_RFLOAT;
          end else phCnt <= phCnt + 1'b1;
        end
        S_RFLOAT: begin
          if (phCnt == FLOAT_L) begin
            state <= S_IDLE;
            doneQ <= 1'b1;
          end else phCnt <= phCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb = '{xclk: 1'b0, pagel: 1'b0, wrN: 1'b1, oeN: 1'b1,
            driveData: 1'b0, load: 1'b0, sample: 1'b0};
    unique case (state)
      S_IDLE:   stb.load = reqValid && opValid;
      S_SETUP:  stb.driveData = (opQ == OP_LATCH);
      S_XHIGH: begin
        stb.xclk      = 1'b1;
        stb.driveData = 1'b1;
      end
      S_XHOLD:  stb.driveData = 1'b1;
      S_PHIGH:  stb.pagel = 1'b1;
      S_WLOW:   stb.wrN = 1'b0;
      S_RWAIT: begin
        stb.oeN    = 1'b0;
        stb.sample = (phCnt == RDV_L);
      end
      default: ;
    endcase
  end

  assign reqReady  = (state == S_IDLE);
  assign doneValid = doneQ;
  assign timedOut  = toQ;

  // R6
  always @(posedge clk)
    if (rstN && state == S_WWAIT && !sawBusy && rdyBsy && busyT > BUSYLOW_L)
      no_late_busy_chk: assert (0) else $error("busy wait passed its window");

endmodule

// File: rtl/ppseq_datapath.sv
module ppseq_datapath
  import ppseq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 7,
  parameter int XHIGH_CYC = 15,
  parameter int PHIGH_CYC = 20,
  parameter int WLOW_CYC  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  ppStrobeT          stb,
  input  logic [DATA_W-1:0] reqData,
  input  logic [1:0]        reqBs,
  input  logic [DATA_W-1:0] tgtDataIn,
  output logic              tgtXclk,
  output logic              tgtPagel,
  output logic              tgtWrN,
  output logic              tgtOeN,
  output logic              tgtBs1,
  output logic              tgtBs2,
  output logic [DATA_W-1:0] tgtDataOut,
  output logic              tgtDataOe,
  output logic [DATA_W-1:0] rdData
);

  localparam int CHK_W = $clog2(maxi(maxi(XHIGH_CYC, PHIGH_CYC), maxi(WLOW_CYC, SETUP_CYC)) + 2) + 1;

  logic [1:0] bsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtXclk    <= 1'b0;
      tgtPagel   <= 1'b0;
      tgtWrN     <= 1'b1;
      tgtOeN     <= 1'b1;
      tgtDataOe  <= 1'b0;
      tgtDataOut <= '0;
      bsQ        <= '0;
      rdData     <= '0;
    end else begin
      tgtXclk   <= stb.xclk;
      tgtPagel  <= stb.pagel;
      tgtWrN    <= stb.wrN;
      tgtOeN    <= stb.oeN;
      tgtDataOe <= stb.driveData;
      if (stb.load) begin
        tgtDataOut <= reqData;
        bsQ        <= reqBs;
      end
      if (stb.sample) rdData <= tgtDataIn;
    end
  end

  assign tgtBs1 = bsQ[0];
  assign tgtBs2 = bsQ[1];

  // Pulse-width observers for the assertions below
  logic [CHK_W-1:0] xHighCnt, pHighCnt, wLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xHighCnt <= '0;
      pHighCnt <= '0;
      wLowCnt  <= '0;
    end else begin
      xHighCnt <= tgtXclk  ? xHighCnt + 1'b1 : '0;
      pHighCnt <= tgtPagel ? pHighCnt + 1'b1 : '0;
      wLowCnt  <= !tgtWrN  ? wLowCnt + 1'b1  : '0;
    end
  end

  // R2
  xclk_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tgtXclk) |-> xHighCnt >= CHK_W'(XHIGH_CYC));
  // R3
  pagel_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tgtPagel) |-> pHighCnt >= CHK_W'(PHIGH_CYC));
  // R4
  wr_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tgtWrN) |-> wLowCnt >= CHK_W'(WLOW_CYC));
  // R4
  bs_at_wr_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tgtWrN) |-> $stable(bsQ));

endmodule

// File: rtl/pp_strobe_seq.sv
module pp_strobe_seq
  import ppseq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SETUP_CYC   = 7,
  parameter int XHIGH_CYC   = 15,
  parameter int XPERIOD_CYC = 30,
  parameter int HOLD_CYC    = 7,
  parameter int PHIGH_CYC   = 20,
  parameter int PL2XH_CYC   = 15,
  parameter int PL2WL_CYC   = 7,
  parameter int WLOW_CYC    = 15,
  parameter int BSHOLD_CYC  = 7,
  parameter int BUSYLOW_MAX = 100,
  parameter int WRITE_MAX   = 450000,
  parameter int ERASE_MAX   = 1200000,
  parameter int RDVALID_CYC = 50,
  parameter int FLOAT_CYC   = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [DATA_W-1:0] reqData,
  input  logic [1:0]        reqBs,
  output logic              reqReady,
  output logic              doneValid,
  output logic              timedOut,
  output logic [DATA_W-1:0] rdData,
  output logic              tgtXclk,
  output logic              tgtPagel,
  output logic              tgtWrN,
  output logic              tgtOeN,
  output logic              tgtBs1,
  output logic              tgtBs2,
  output logic [DATA_W-1:0] tgtDataOut,
  output logic              tgtDataOe,
  input  logic [DATA_W-1:0] tgtDataIn,
  input  logic              tgtRdy
);

  ppStrobeT stb;

  ppseq_ctrl #(
    .SETUP_CYC(SETUP_CYC), .XHIGH_CYC(XHIGH_CYC), .XPERIOD_CYC(XPERIOD_CYC),
    .HOLD_CYC(HOLD_CYC), .PHIGH_CYC(PHIGH_CYC), .PL2XH_CYC(PL2XH_CYC),
    .PL2WL_CYC(PL2WL_CYC), .WLOW_CYC(WLOW_CYC), .BSHOLD_CYC(BSHOLD_CYC),
    .BUSYLOW_MAX(BUSYLOW_MAX), .WRITE_MAX(WRITE_MAX), .ERASE_MAX(ERASE_MAX),
    .RDVALID_CYC(RDVALID_CYC), .FLOAT_CYC(FLOAT_CYC)
  ) ctrlU (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .rdyBsy(tgtRdy), .stb(stb), .reqReady(reqReady),
    .doneValid(doneValid), .timedOut(timedOut)
  );

  ppseq_datapath #(
    .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC), .XHIGH_CYC(XHIGH_CYC),
    .PHIGH_CYC(PHIGH_CYC), .WLOW_CYC(WLOW_CYC)
  ) dpU (
    .clk(clk), .rstN(rstN), .stb(stb), .reqData(reqData), .reqBs(reqBs),
    .tgtDataIn(tgtDataIn), .tgtXclk(tgtXclk), .tgtPagel(tgtPagel),
    .tgtWrN(tgtWrN), .tgtOeN(tgtOeN), .tgtBs1(tgtBs1), .tgtBs2(tgtBs2),
    .tgtDataOut(tgtDataOut), .tgtDataOe(tgtDataOe), .rdData(rdData)
  );

  // R1
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (tgtWrN && tgtOeN && !tgtXclk && !tgtPagel));
  // R1
  busy_req_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> $stable({tgtBs2, tgtBs1, tgtDataOut}));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  // R8
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tgtOeN |-> !tgtDataOe);

endmodule

// File: tb/pp_strobe_seq_test.sv
module pp_strobe_seq_test;
  import ppseq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int SETUP = 7, XHIGH = 15, XHOLD = 15, PHIGH = 20, PTAIL = 15;
  localparam int WLOW = 15, BSHOLD = 7, RDV = 50, FLOAT = 50;
  localparam int NV = 10;
  localparam int VOP[NV]   = '{0, 1, 2, 4, 2, 2, 4, 3, 2, 2};
  localparam int VDATA[NV] = '{'hA5, 0, 0, 0, 0, 0, 0, 'h3C, 0, 0};
  localparam int VBS[NV]   = '{1, 1, 0, 3, 0, 2, 3, 2, 1, 0};
  localparam int VDLY[NV]  = '{-1, -1, 3, 3, 3, -1, 3, -1, 150, 0};
  localparam int VLEN[NV]  = '{0, 0, 100, 450, 450, 0, 800, 0, 10, 3};
  localparam int VTO[NV]   = '{0, 0, 0, 0, 1, 1, 1, 0, 1, 0};

  logic clk = 0, rstN = 0, reqValid = 0;
  logic [2:0] reqOp = 0;
  logic [7:0] reqData = 0;
  logic [1:0] reqBs = 0;
  logic reqReady, doneValid, timedOut;
  logic [7:0] rdData, tgtDataOut;
  logic tgtXclk, tgtPagel, tgtWrN, tgtOeN, tgtBs1, tgtBs2, tgtDataOe;
  logic [7:0] tgtDataIn = 0;
  logic tgtRdy = 1;

  int checks = 0, errors = 0, cyc = 0;
  int curOp = 0, busyDelay = -1, busyLen = 0, tgtVal = 0;
  bit finished = 0;

  pp_strobe_seq #(.WRITE_MAX(300), .ERASE_MAX(600)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqData(reqData), .reqBs(reqBs), .reqReady(reqReady),
    .doneValid(doneValid), .timedOut(timedOut), .rdData(rdData),
    .tgtXclk(tgtXclk), .tgtPagel(tgtPagel), .tgtWrN(tgtWrN), .tgtOeN(tgtOeN),
    .tgtBs1(tgtBs1), .tgtBs2(tgtBs2), .tgtDataOut(tgtDataOut),
    .tgtDataOe(tgtDataOe), .tgtDataIn(tgtDataIn), .tgtRdy(tgtRdy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input int i);
    case (i)
      0: return "R2 latch";
      1: return "R3 page-load";
      2: return "R5 write handshake";
      3: return "R7 erase above write limit";
      4: return "R7 write busy too long";
      5: return "R6 busy never seen";
      6: return "R7 erase busy too long";
      7: return "R8 read";
      8: return "R6 busy too late";
      default: return "R5 busy inside write pulse";
    endcase
  endfunction

  // Monitor and target model, all at the falling edge
  logic prevX = 0, prevP = 0, prevW = 1, prevO = 1, prevR = 1;
  logic [9:0] prevSig = 0;
  int sc = 0, xh = 0, ph = 0, wl = 0, xFall = 0, pFall = 0, oRise = 0, rRise = 0;
  int rc = 0, oeCnt = 0, doneCount = 0, xRises = 0;
  bit armed = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if ({tgtBs2, tgtBs1, tgtDataOut} != prevSig) sc = 0; else sc++;
      if (tgtXclk && !prevX) begin xRises++; chk(sc >= SETUP, "R2 setup before latch rise", sc, SETUP); end
      if (tgtXclk) xh++;
      if (!tgtXclk && prevX) begin chk(xh >= XHIGH, "R2 latch high width", xh, XHIGH); xh = 0; xFall = cyc; end
      if (tgtPagel && !prevP) chk(sc >= SETUP, "R3 select before page-load rise", sc, SETUP);
      if (tgtPagel) ph++;
      if (!tgtPagel && prevP) begin chk(ph >= PHIGH, "R3 page-load width", ph, PHIGH); ph = 0; pFall = cyc; end
      if (!tgtWrN && prevW) begin chk(sc >= SETUP, "R4 select before write fall", sc, SETUP); armed = 1; rc = 0; end
      else if (armed) rc++;
      if (!tgtWrN) wl++;
      if (tgtWrN && !prevW) begin chk(wl >= WLOW, "R4 write low width", wl, WLOW); wl = 0; end
      if (tgtOeN && !prevO) oRise = cyc;
      if (tgtRdy && !prevR) rRise = cyc;
      if (doneValid) begin
        doneCount++;
        if (curOp == 0) chk(cyc - xFall + 1 >= XHOLD, "R2 hold after latch fall", cyc - xFall + 1, XHOLD);
        if (curOp == 1) chk(cyc - pFall + 1 >= PTAIL, "R3 tail after page-load fall", cyc - pFall + 1, PTAIL);
        if (curOp == 3) chk(cyc - oRise + 1 >= FLOAT, "R9 float before done", cyc - oRise + 1, FLOAT);
        if ((curOp == 2 || curOp == 4) && !timedOut)
          chk(cyc - rRise + 1 >= BSHOLD, "R5 select hold after ready", cyc - rRise + 1, BSHOLD);
      end
      if (reqValid && reqReady) armed = 0;
    end
    prevX = tgtXclk; prevP = tgtPagel; prevW = tgtWrN; prevO = tgtOeN; prevR = tgtRdy;
    prevSig = {tgtBs2, tgtBs1, tgtDataOut};
    oeCnt = tgtOeN ? 0 : oeCnt + 1;
    tgtDataIn = (oeCnt >= RDV) ? 8'(tgtVal) : ~8'(tgtVal);
    tgtRdy = !(armed && busyDelay >= 0 && rc >= busyDelay && rc < busyDelay + busyLen);
  end

  task automatic issue(input int op, input int data, input int bs);
    while (!reqReady) @(negedge clk);
    reqOp = 3'(op); reqData = 8'(data); reqBs = 2'(bs); reqValid = 1;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic waitDone();
    while (!doneValid) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady && tgtWrN && tgtOeN && !tgtXclk && !tgtPagel && !doneValid,
        "R1 idle after reset", {reqReady, tgtWrN, tgtOeN, tgtXclk, tgtPagel}, 5'b11100);

    for (int i = 0; i < NV; i++) begin
      curOp = VOP[i]; busyDelay = VDLY[i]; busyLen = VLEN[i]; tgtVal = VDATA[i];
      @(negedge clk);
      chk(tgtWrN && tgtOeN && !tgtXclk && !tgtPagel, "R1 idle strobes between ops",
          {tgtWrN, tgtOeN, tgtXclk, tgtPagel}, 4'b1100);
      issue(VOP[i], VDATA[i], VBS[i]);
      waitDone();
      chk(timedOut == VTO[i][0], tagOf(i), int'(timedOut), VTO[i]);
      if (VOP[i] == 0) chk(tgtDataOut == 8'(VDATA[i]), "R2 latch byte on bus", tgtDataOut, VDATA[i]);
      if (VOP[i] == 3) chk(rdData == 8'(VDATA[i]), "R8 read data after valid window", rdData, VDATA[i]);
      if (VOP[i] != 3) chk({tgtBs2, tgtBs1} == 2'(VBS[i]), "R5 select lines held", {tgtBs2, tgtBs1}, VBS[i]);
      @(negedge clk);
      chk(!doneValid && !timedOut, "R10 completion is one cycle", {doneValid, timedOut}, 0);
    end

    // R1 request during an erase is ignored
    begin
      int dc0, xr0;
      curOp = 4; busyDelay = 3; busyLen = 200; tgtVal = 0;
      issue(4, 0, 2);
      dc0 = doneCount; xr0 = xRises;
      repeat (20) @(negedge clk);
      reqOp = 3'd0; reqData = 8'h5A; reqBs = 2'd3; reqValid = 1;
      @(negedge clk);
      reqValid = 0;
      chk(!reqReady, "R1 busy during erase", reqReady, 0);
      waitDone();
      chk(!timedOut, "R7 erase within limit", timedOut, 0);
      repeat (60) @(negedge clk);
      chk(tgtDataOut == 8'h00 && {tgtBs2, tgtBs1} == 2'd2, "R1 busy request left bus alone",
          {tgtBs2, tgtBs1, tgtDataOut}, {2'd2, 8'h00});
      chk(xRises == xr0 && doneCount == dc0 + 1, "R1 busy request made no operation",
          doneCount - dc0, 1);
    end

    // R1 unknown operation code ignored
    begin
      int dc1;
      dc1 = doneCount;
      reqOp = 3'd7; reqData = 8'hFF; reqBs = 2'd1; reqValid = 1;
      @(negedge clk);
      reqValid = 0;
      @(negedge clk);
      chk(reqReady, "R1 unknown code not accepted", reqReady, 1);
      repeat (40) @(negedge clk);
      chk(doneCount == dc1 && tgtDataOut == 8'h00, "R1 unknown code no completion",
          doneCount - dc1, 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule